// File: doc/BRIEF.md
# Synchronous Burst Static Memory

This block models a single-port synchronous static memory with a 32-bit data path split into four 8-bit byte lanes and a small parameterised depth. An access begins when one of two active-low address strobes is asserted. One strobe belongs to the processor and the other to a memory controller. Three chip enables qualify the strobe. The low two bits of the captured address seed a 2-bit burst counter, and the counter then steps through the four words of an aligned group on each advance request.

Every access cycle is either a write or a read. A global write stores all four lanes. A byte write stores only the selected lanes. With no write requested, the addressed word is read and registered, so the data appears after the next rising edge. A processor-strobe write is deferred by one cycle, and its write controls are taken from the cycle after the address cycle. The output-valid flag combines the registered read, the output enable and a mask for the first read after a deselect. A sleep input stops all accesses and leaves the stored data intact.

Top module: `sync_burst_sram`

## Requirements
- R1: At a rising edge where a strobe takes effect and all enables are active (ce1_n low, ce2 high, ce3_n low), `addr_i` becomes the current address and its bits [1:0] seed the burst counter.
- R2: When both strobes are low in the same cycle and ce1_n is low, the processor strobe wins. The access is a processor access, so no write occurs in that cycle.
- R3: With ce1_n high, the processor strobe is treated as absent. An ongoing burst continues unchanged.
- R4: A strobe that takes effect while any enable is inactive deselects the block. In cycles without a strobe, the enables have no effect.
- R5: In a cycle with no strobe and adv_n low, an active burst increments the address bits [1:0] modulo 4 (3 wraps to 0). The upper address bits are held.
- R6: In a cycle with no strobe and adv_n high, the address is held. A write goes to the same word again, and a read returns the same word again.
- R7: gw_n low writes all four lanes of `wdata`, whatever bwe_n and bsel_n are.
- R8: With gw_n high and bwe_n low, lane k (bits 8k+7:8k) is written exactly when bsel_n[k] is low. With no lane selected, the cycle is a read.
- R9: A processor-strobe access performs no write in its address cycle. In the next cycle, the write controls write the loaded address, and adv_n is ignored in that cycle.
- R10: Read data for the access address of a clock edge is on `rdata` after that edge. `rvalid` is high when that cycle was a read and oe_n is low.
- R11: The first access cycle after a deselected or sleeping state keeps `rvalid` low for its read.
- R12: While sleep is high, nothing is read or written and the block deselects. `rvalid` is low after sleep ends, until a new access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | AW | Word address |
| strb_cpu_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte select, active low |
| oe_n | input | 1 | Output enable, active low, combinational |
| sleep | input | 1 | Sleep, active high |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| rvalid | output | 1 | Read data valid |

## Verification
If the burst counter or the held address register is wrong, the very next read returns another word's data, one edge after the bad step. A wrong deferred-write flag shows up as a word written one cycle early or at an advanced address, and the bench sees this on the next readback of that word. A stale deselect or first-read mask state changes `rvalid` in the cycle right after the edge that should have set it. The bench therefore compares both outputs after every single edge against a model built from the requirements.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  localparam int LANES   = 4;
  localparam int LANE_W  = 8;
  localparam int DATA_W  = LANES * LANE_W;
  localparam int BURST_W = 2;
  typedef logic [LANES-1:0]  lane_mask_t;
  typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/bs_addr_ctrl.sv
module bs_addr_ctrl #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          sleep,
  output logic [AW-1:0] cur_addr,
  output logic          acc_en,
  output logic          wr_block,
  output logic          first_acc
);
  import burst_sram_pkg::*;
  localparam int UW = AW - BURST_W;

  logic [AW-1:0] addr_q, addr_d;
  logic          act_q, act_d;
  logic          pend_q, pend_d;
  logic          cpu_go, ctl_go, strobe, sel;
  logic          addr_en;

  always_comb begin
    cpu_go    = !strb_cpu_n && !ce1_n;
    ctl_go    = !strb_ctl_n && !cpu_go;
    strobe    = cpu_go || ctl_go;
    sel       = !ce1_n && ce2 && !ce3_n;
    addr_d    = addr_q;
    act_d     = act_q;
    pend_d    = 1'b0;
    acc_en    = 1'b0;
    wr_block  = 1'b0;
    first_acc = 1'b0;
    if (sleep) begin
      act_d = 1'b0;
    end else if (strobe && sel) begin
      addr_d    = addr_i;
      act_d     = 1'b1;
      pend_d    = cpu_go;
      acc_en    = 1'b1;
      wr_block  = cpu_go;
      first_acc = !act_q;
    end else if (strobe) begin
      act_d = 1'b0;
    end else if (act_q) begin
      acc_en = 1'b1;
      if (!pend_q && !adv_n)
        addr_d = {addr_q[AW-1:BURST_W], addr_q[BURST_W-1:0] + 2'd1};
    end
    cur_addr = addr_d;
    addr_en  = (addr_d != addr_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (addr_en) addr_q <= addr_d;
      act_q  <= act_d;
      pend_q <= pend_d;
    end
  end

  // R2
  cpu_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_cpu_n && !strb_ctl_n && !ce1_n && ce2 && !ce3_n && !sleep) |=> (pend_q && act_q));

  // R5
  burst_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !pend_q && !sleep && strb_ctl_n && (strb_cpu_n || ce1_n) && !adv_n)
    |=> (addr_q[BURST_W-1:0] == $past(addr_q[BURST_W-1:0]) + 2'd1)
        && (addr_q[AW-1:BURST_W] == $past(addr_q[AW-1:BURST_W])));

  // R3
  cpu_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !sleep && ce1_n && strb_ctl_n && adv_n) |=> ($stable(addr_q) && act_q));

  // R9
  defer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !sleep && strb_ctl_n && (strb_cpu_n || ce1_n)) |-> (cur_addr == addr_q));

  logic [UW-1:0] unused_upper;
  assign unused_upper = '0;
endmodule

// File: rtl/bs_wr_decode.sv
module bs_wr_decode (
  input  logic                            gw_n,
  input  logic                            bwe_n,
  input  logic [burst_sram_pkg::LANES-1:0] bsel_n,
  input  logic                            acc_en,
  input  logic                            wr_block,
  output logic [burst_sram_pkg::LANES-1:0] lane_we,
  output logic                            rd_en
);
  import burst_sram_pkg::*;
  lane_mask_t req;

  always_comb begin
    if (!gw_n)       req = '1;
    else if (!bwe_n) req = ~bsel_n;
    else             req = '0;
    lane_we = (acc_en && !wr_block) ? req : '0;
    rd_en   = acc_en && (lane_we == '0);
  end
endmodule

// File: rtl/bs_lane_mem.sv
module bs_lane_mem #(
  parameter int AW = 6,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          we,
  input  logic          re,
  input  logic [W-1:0]  wd,
  output logic [W-1:0]  rd
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd <= '0;
    else if (re) rd <= mem[addr];
  end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic          strb_cpu_n,
  input  logic          strb_ctl_n,
  input  logic          adv_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          gw_n,
  input  logic          bwe_n,
  input  logic [3:0]    bsel_n,
  input  logic          oe_n,
  input  logic          sleep,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata,
  output logic          rvalid
);
  import burst_sram_pkg::*;

  logic [AW-1:0] cur_addr;
  logic          acc_en, wr_block, first_acc, rd_en;
  lane_mask_t    lane_we;
  logic          rd_q, mask_q;

  bs_addr_ctrl #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .sleep(sleep),
    .cur_addr(cur_addr), .acc_en(acc_en), .wr_block(wr_block),
    .first_acc(first_acc)
  );

  bs_wr_decode u_wr (
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .acc_en(acc_en),
    .wr_block(wr_block), .lane_we(lane_we), .rd_en(rd_en)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    bs_lane_mem #(.AW(AW), .W(LANE_W)) u_mem (
      .clk(clk), .rst_n(rst_n), .addr(cur_addr),
      .we(lane_we[k]), .re(rd_en),
      .wd(wdata[k*LANE_W +: LANE_W]),
      .rd(rdata[k*LANE_W +: LANE_W])
    );
  end

  logic rd_d, mask_d;
  always_comb begin
    rd_d   = rd_en;
    mask_d = acc_en && first_acc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      rd_q   <= rd_d;
      mask_q <= mask_d;
    end
  end

  assign rvalid = rd_q && !mask_q && !oe_n;

  // R12
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0) ##1 !rvalid);

  // R11
  first_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && first_acc) |=> !rvalid);

  // R7
  global_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!gw_n && acc_en && !wr_block) |-> (lane_we == '1));

  // R10
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(rd_en));
endmodule

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] addr_i;
  logic strb_cpu_n, strb_ctl_n, adv_n, ce1_n, ce2, ce3_n;
  logic gw_n, bwe_n, oe_n, sleep;
  logic [3:0] bsel_n;
  logic [31:0] wdata, rdata;
  logic rvalid;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sync_burst_sram #(.AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .gw_n(gw_n), .bwe_n(bwe_n),
    .bsel_n(bsel_n), .oe_n(oe_n), .sleep(sleep), .wdata(wdata),
    .rdata(rdata), .rvalid(rvalid)
  );

  // reference state built from the requirements
  logic [31:0] ref_mem [DEPTH];
  logic [AW-1:0] m_addr;
  bit m_act, m_pend, m_rd, m_mask;
  logic [31:0] m_rdata;

  function automatic logic [31:0] pat(input int a, input int salt);
    return (32'h9E3779B1 * (a + 1)) ^ (salt * 32'h01010101);
  endfunction

  task automatic model_step();
    bit cpu, ctl, sel, load, was;
    logic [3:0] req;
    m_mask = 0;
    if (sleep) begin m_act = 0; m_pend = 0; m_rd = 0; return; end
    cpu = !strb_cpu_n && !ce1_n;
    ctl = !strb_ctl_n && !cpu;
    sel = !ce1_n && ce2 && !ce3_n;
    load = 0;
    was = m_act;
    if (cpu || ctl) begin
      if (!sel) begin m_act = 0; m_pend = 0; m_rd = 0; return; end
      m_addr = addr_i; m_act = 1; load = 1;
    end else if (m_act) begin
      if (!m_pend && !adv_n) m_addr[1:0] = m_addr[1:0] + 2'd1;
    end else begin
      m_rd = 0; m_pend = 0; return;
    end
    req = !gw_n ? 4'hF : (!bwe_n ? ~bsel_n : 4'h0);
    if (load && cpu) req = 4'h0;
    m_pend = load && cpu;
    m_mask = load && !was;
    if (req != 0) begin
      for (int k = 0; k < 4; k++)
        if (req[k]) ref_mem[m_addr][k*8 +: 8] = wdata[k*8 +: 8];
      m_rd = 0;
    end else begin
      m_rdata = ref_mem[m_addr];
      m_rd = 1;
    end
  endtask

  task automatic tick(input string tag);
    bit ev;
    @(posedge clk);
    model_step();
    @(negedge clk);
    ev = m_rd && !m_mask && !oe_n;
    compared++;
    if (rvalid !== ev) begin
      mismatched++;
      $display("FAIL %s rvalid actual=%0b expected=%0b", tag, rvalid, ev);
    end
    if (ev) begin
      compared++;
      if (rdata !== m_rdata) begin
        mismatched++;
        $display("FAIL %s rdata actual=%h expected=%h", tag, rdata, m_rdata);
      end
    end
  endtask

  task automatic idle();
    strb_cpu_n = 1; strb_ctl_n = 1; adv_n = 1;
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    gw_n = 1; bwe_n = 1; bsel_n = 4'hF;
    oe_n = 0; sleep = 0; wdata = '0;
  endtask

  task automatic ctl_load(input int a);
    idle(); strb_ctl_n = 0; addr_i = AW'(a);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    idle(); addr_i = '0; rst_n = 0;
    m_act = 0; m_pend = 0; m_rd = 0; m_mask = 0; m_addr = '0; m_rdata = '0;
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    compared++;
    if (rvalid !== 1'b0 || rdata !== 32'h0) begin
      mismatched++;
      $display("FAIL reset rvalid=%0b rdata=%h expected 0/0", rvalid, rdata);
    end
    rst_n = 1;

    // fill every word: controller-strobe global writes, bursts of four
    for (int b = 0; b < DEPTH / 4; b++) begin
      ctl_load(b * 4); gw_n = 0; bwe_n = 0; bsel_n = 4'(b);
      wdata = pat(b * 4, 0);
      tick("R1 R7 fill load");
      for (int i = 1; i < 4; i++) begin
        idle(); adv_n = 0; gw_n = 0; wdata = pat(b * 4 + i, 0);
        ce2 = 0; ce3_n = 1; addr_i = AW'(i * 7);
        tick("R5 R4 fill advance");
      end
    end

    // read bursts from every start offset, covering counter wrap
    for (int s = 0; s < DEPTH; s++) begin
      ctl_load(s);
      tick("R1 R10 read load");
      for (int i = 0; i < 4; i++) begin
        idle(); adv_n = 0;
        tick("R5 wrap read");
      end
      idle(); oe_n = s[0];
      tick("R6 R10 hold read");
    end

    // all byte-select patterns
    for (int m = 0; m < 16; m++) begin
      ctl_load(m + 8); bwe_n = 0; bsel_n = 4'(m); wdata = pat(m, 3);
      tick("R8 byte write");
      idle();
      tick("R6 R8 readback");
    end

    // hold with repeated write to the same word
    ctl_load(40); gw_n = 0; wdata = 32'h1111_2222;
    tick("R7 write");
    idle(); gw_n = 0; wdata = 32'h3333_4444;
    tick("R6 rewrite same word");
    idle();
    tick("R6 readback");

    // processor write: deferred by one cycle, adv ignored then
    idle(); strb_cpu_n = 0; addr_i = AW'(21); gw_n = 0; adv_n = 0; wdata = 32'hDEAD_0001;
    tick("R9 address cycle");
    idle(); gw_n = 0; adv_n = 0; wdata = 32'hBEEF_0002;
    tick("R9 data cycle");
    idle(); adv_n = 0;
    tick("R9 next word read");
    ctl_load(21);
    tick("R9 readback");
    ctl_load(20);
    tick("R9 neighbour untouched");

    // priority: both strobes, processor wins, no write this cycle
    idle(); strb_cpu_n = 0; strb_ctl_n = 0; addr_i = AW'(30); gw_n = 0; wdata = 32'hFFFF_0000;
    tick("R2 both strobes");
    idle();
    tick("R2 deferred read");

    // processor strobe with ce1_n high is ignored
    ctl_load(33);
    tick("R3 setup");
    idle(); strb_cpu_n = 0; ce1_n = 1; addr_i = AW'(50);
    tick("R3 gated strobe");
    idle(); strb_cpu_n = 0; ce1_n = 1; adv_n = 0; addr_i = AW'(50);
    tick("R3 gated strobe advance");

    // deselect, then masked first read
    ctl_load(12); ce3_n = 1;
    tick("R4 deselect");
    idle(); gw_n = 0; adv_n = 0; wdata = 32'h5555_5555;
    tick("R4 idle write ignored");
    ctl_load(12);
    tick("R11 first read masked");
    idle(); adv_n = 0;
    tick("R11 second read");

    // sleep blocks access and preserves data
    ctl_load(44); gw_n = 0; wdata = 32'hAAAA_0044;
    tick("R12 before sleep");
    for (int i = 0; i < 3; i++) begin
      idle(); sleep = 1; strb_ctl_n = 0; addr_i = AW'(44 + i);
      gw_n = 0; wdata = 32'h0BAD_0000;
      tick("R12 sleeping");
    end
    idle();
    tick("R12 after sleep");
    ctl_load(44);
    tick("R11 R12 masked after sleep");
    idle(); adv_n = 0;
    tick("R12 preserved");
    idle(); adv_n = 0;
    tick("R12 preserved next");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule